// File: doc/BRIEF.md
# Flash Byte Program Controller

This block programs a single byte into a parallel NOR-type flash device on behalf of a host. The host presents an address and a data byte with a request. The controller first runs the device's program entry sequence of four write cycles: two unlock writes, a program command, and the write of the target address and data. It then reads the device repeatedly until the write finishes or fails. It reports exactly one outcome per request.

While a program is in flight, the device answers every read with a status byte. Bit 7 of that byte is the inverse of bit 7 of the byte being written, and bit 5 signals an internal failure. When bit 7 first matches, the controller reads once more and compares the whole byte, because the other bits may still be settling. When the device reports a failure, or a poll limit on the host side runs out, the controller writes a reset command so the device returns to read mode, and only then signals the error.

Bus strobes are synchronous to the controller clock. Each strobe lasts a parameterised number of cycles, and read data is sampled on the last cycle of a read strobe.

Top module: `fbp_ctrl`

## Requirements
- R1: A request produces four write strobes in this order: (0xAAA, 0xAA), (0x555, 0x55), (0xAAA, 0xA0), then (request address, request data), written as (address, data). Each write strobe stays high for exactly CYC_LEN cycles, and address and data are held steady while it is high.
- R2: `req` is accepted only while `busy` is low. Acceptance gives a one-cycle `ack` pulse and raises `busy`. A `req` that arrives while `busy` is high produces no `ack` and causes no change in the bus cycles of the operation already running.
- R3: After the data write, the controller reads the request address. It keeps polling while bit 7 of the value read differs from bit 7 of the request data and bit 5 of that value is 0.
- R4: On the first poll whose bit 7 matches, exactly one further read is made. If all 8 bits of that read equal the request data, `done` pulses.
- R5: If that confirming read differs in any bit, `verify_fail` pulses and no reset write is issued.
- R6: A poll with bit 7 mismatched and bit 5 set ends polling. A reset write (0x000, 0xF0) follows, then `error` pulses. Bit 5 is ignored on a poll whose bit 7 matches.
- R7: If MAX_POLLS polls all show bit 7 mismatched with bit 5 clear, the controller issues the reset write (0x000, 0xF0) and then pulses `error`.
- R8: Each accepted request ends with exactly one single-cycle pulse on one of `done`, `error` or `verify_fail`. `busy` is low in that cycle.
- R9: After reset, all outputs are low. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Program request |
| req_addr | input | ADDR_W | Byte address to program |
| req_data | input | 8 | Byte to program |
| ack | output | 1 | One-cycle pulse when a request is taken |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: byte written and confirmed |
| error | output | 1 | Pulse: device failure or poll timeout, reset already sent |
| verify_fail | output | 1 | Pulse: confirming read did not match |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Write strobe, active high |
| fl_oe | output | 1 | Read strobe, active high |
| fl_rdata | input | 8 | Flash read data |

## Verification
A wrong sequencer step shows at the bus within one strobe: an unlock pair in the wrong order or a missing command write appears in the logged write list before any polling begins. A wrong polling decision shows when the operation ends. Stopping on the first bit-7 match, ignoring bit 5, or counting the poll limit wrongly each changes either the number of reads or which outcome pulse fires. A stale state after an outcome shows on the next request as an extra `ack`, or as bus activity before the unlock writes.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int BIT_DONE_POL = 7;
    localparam int BIT_DEV_FAIL = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_CONF,
        ST_RST
    } fbp_state_e;

    typedef struct packed {
        logic done;
        logic err;
        logic vfail;
    } fbp_result_t;

    function automatic logic pol_match(input logic [7:0] stat, input logic [7:0] want);
        return stat[BIT_DONE_POL] == want[BIT_DONE_POL];
    endfunction

    function automatic logic dev_failed(input logic [7:0] stat, input logic [7:0] want);
        return (stat[BIT_DONE_POL] != want[BIT_DONE_POL]) && stat[BIT_DEV_FAIL];
    endfunction

endpackage

// File: rtl/fbp_bus.sv
module fbp_bus #(
    parameter int ADDR_W  = 12,
    parameter int CYC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [7:0]        go_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_oe,
    input  logic [7:0]        fl_rdata,
    output logic              fin,
    output logic [7:0]        rd_q
);
    localparam int CW = $clog2(CYC_LEN + 1);

    logic          act;
    logic          is_wr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            act      <= 1'b0;
            is_wr    <= 1'b0;
            cnt      <= '0;
            fin      <= 1'b0;
            rd_q     <= '0;
            fl_addr  <= '0;
            fl_wdata <= '0;
        end else begin
            fin <= 1'b0;
            if (act) begin
                if (cnt == '0) begin
                    act <= 1'b0;
                    fin <= 1'b1;
                    if (!is_wr) rd_q <= fl_rdata;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (go) begin
                act      <= 1'b1;
                is_wr    <= go_wr;
                cnt      <= CW'(CYC_LEN - 1);
                fl_addr  <= go_addr;
                fl_wdata <= go_data;
            end
        end
    end

    assign fl_we = act && is_wr;
    assign fl_oe = act && !is_wr;

    AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_oe)); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (fl_we || fl_oe) && $past(fl_we || fl_oe) |-> $stable(fl_addr) && $stable(fl_wdata)); // R1
    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        go |-> !act); // R1

endmodule

// File: rtl/fbp_wdog.sv
module fbp_wdog #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(MAX_POLLS - 1));

    AST_WDOG_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(MAX_POLLS)); // R7

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
    import fbp_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                CYC_LEN    = 2,
    parameter int                MAX_POLLS  = 1024,
    parameter logic [ADDR_W-1:0] UNLK1_ADDR = 'hAAA,
    parameter logic [7:0]        UNLK1_DATA = 8'hAA,
    parameter logic [ADDR_W-1:0] UNLK2_ADDR = 'h555,
    parameter logic [7:0]        UNLK2_DATA = 8'h55,
    parameter logic [ADDR_W-1:0] PROG_ADDR  = 'hAAA,
    parameter logic [7:0]        PROG_DATA  = 8'hA0,
    parameter logic [ADDR_W-1:0] RST_ADDR   = 'h000,
    parameter logic [7:0]        RST_DATA   = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              ack,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              verify_fail,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_oe,
    input  logic [7:0]        fl_rdata
);
    fbp_state_e        state;
    logic [1:0]        step;
    logic              go;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    fbp_result_t       res;

    logic              go_wr;
    logic [ADDR_W-1:0] go_addr;
    logic [7:0]        go_data;
    logic              fin;
    logic [7:0]        rd_q;
    logic              wd_clr, wd_inc, wd_exp;
    logic              poll_ok, poll_bad;

    assign poll_ok  = pol_match(rd_q, tgt_data);
    assign poll_bad = dev_failed(rd_q, tgt_data);

    always_comb begin
        go_wr   = 1'b0;
        go_addr = tgt_addr;
        go_data = tgt_data;
        unique case (state)
            ST_CMD: begin
                go_wr = 1'b1;
                unique case (step)
                    2'd0:    begin go_addr = UNLK1_ADDR; go_data = UNLK1_DATA; end
                    2'd1:    begin go_addr = UNLK2_ADDR; go_data = UNLK2_DATA; end
                    2'd2:    begin go_addr = PROG_ADDR;  go_data = PROG_DATA;  end
                    default: begin go_addr = tgt_addr;   go_data = tgt_data;   end
                endcase
            end
            ST_RST: begin
                go_wr   = 1'b1;
                go_addr = RST_ADDR;
                go_data = RST_DATA;
            end
            default: ;
        endcase
    end

    assign wd_clr = (state == ST_IDLE);
    assign wd_inc = (state == ST_POLL) && fin && !poll_ok && !poll_bad && !wd_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step     <= '0;
            go       <= 1'b0;
            ack      <= 1'b0;
            res      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else begin
            go  <= 1'b0;
            ack <= 1'b0;
            res <= '0;
            unique case (state)
                ST_IDLE: if (req) begin
                    tgt_addr <= req_addr;
                    tgt_data <= req_data;
                    ack      <= 1'b1;
                    step     <= '0;
                    go       <= 1'b1;
                    state    <= ST_CMD;
                end
                ST_CMD: if (fin) begin
                    go <= 1'b1;
                    if (step == 2'd3) state <= ST_POLL;
                    else              step  <= step + 1'b1;
                end
                ST_POLL: if (fin) begin
                    go <= 1'b1;
                    if (poll_ok)                state <= ST_CONF;
                    else if (poll_bad || wd_exp) state <= ST_RST;
                end
                ST_CONF: if (fin) begin
                    state <= ST_IDLE;
                    if (rd_q == tgt_data) res.done  <= 1'b1;
                    else                  res.vfail <= 1'b1;
                end
                ST_RST: if (fin) begin
                    state   <= ST_IDLE;
                    res.err <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign done        = res.done;
    assign error       = res.err;
    assign verify_fail = res.vfail;

    fbp_bus #(.ADDR_W(ADDR_W), .CYC_LEN(CYC_LEN)) u_bus (
        .clk(clk), .rst(rst), .go(go), .go_wr(go_wr), .go_addr(go_addr),
        .go_data(go_data), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_oe(fl_oe), .fl_rdata(fl_rdata), .fin(fin), .rd_q(rd_q)
    );

    fbp_wdog #(.MAX_POLLS(MAX_POLLS)) u_wdog (
        .clk(clk), .rst(rst), .clr(wd_clr), .inc(wd_inc), .expired(wd_exp)
    );

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, error, verify_fail})); // R8
    AST_RESULT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done || error || verify_fail) |-> !busy); // R8
    AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(!busy)); // R2
    AST_RESET_BEFORE_ERR: assert property (@(posedge clk) disable iff (rst)
        error |-> $past(fl_we, 2) && ($past(fl_wdata, 2) == RST_DATA)); // R6
    AST_READ_BEFORE_OK: assert property (@(posedge clk) disable iff (rst)
        (done || verify_fail) |-> $past(fl_oe, 2)); // R4

endmodule

// File: tb/fbp_ctrl_tb.sv
`timescale 1ns/100ps
module fbp_ctrl_tb;
    localparam int AW   = 12;
    localparam int CYC  = 2;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic ack, busy, done, error, verify_fail, fl_we, fl_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_wdata;
    logic [7:0] rd_reg = '0;

    always #2.5 clk = ~clk;

    fbp_ctrl #(.ADDR_W(AW), .CYC_LEN(CYC), .MAX_POLLS(MAXP)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
        .ack(ack), .busy(busy), .done(done), .error(error), .verify_fail(verify_fail),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_oe(fl_oe),
        .fl_rdata(rd_reg)
    );

    int total = 0;
    int fails = 0;
    int cyc = 0;

    // flash model state, driven at the falling edge
    logic       m_clr = 1'b0;
    logic [7:0] m_d = '0;
    int         m_busy = 0;
    int         m_mode = 0;   // 0 completes, 1 reports bit 5, 2 never completes
    bit         m_glitch = 0, m_corrupt = 0, m_b5m = 0;
    int         wcnt = 0, rcnt = 0, wlen_bad = 0, run = 0, acks = 0;
    logic [AW-1:0] wa [8];
    logic [7:0]    wd [8];
    logic pwe = 1'b0, poe = 1'b0;

    function automatic logic [7:0] status_of(int i, bit b5);
        logic [7:0] s;
        s = {~m_d[7], i[0], b5, m_d[4:0]};
        return s;
    endfunction

    function automatic logic [7:0] model_val(int i);
        logic [7:0] v;
        if (m_mode == 2) return status_of(i, 1'b0);
        if (i < m_busy)  return status_of(i, 1'b0);
        if (m_mode == 1) return status_of(i, 1'b1);
        if (i == m_busy) begin
            v = m_d;
            if (m_glitch) v[6:0] = ~m_d[6:0];
            if (m_b5m)    v[5]   = 1'b1;
            return v;
        end
        return m_corrupt ? (m_d ^ 8'h01) : m_d;
    endfunction

    always @(negedge clk) begin
        if (m_clr) begin
            wcnt = 0; rcnt = 0; wlen_bad = 0; run = 0; acks = 0;
        end else begin
            if (fl_we) run++;
            else if (pwe) begin
                if (run != CYC) wlen_bad++;
                run = 0;
            end
            if (fl_we && !pwe) begin
                if (wcnt < 8) begin wa[wcnt] = fl_addr; wd[wcnt] = fl_wdata; end
                wcnt++;
            end
            if (fl_oe && !poe) begin
                rd_reg = model_val(rcnt);
                rcnt++;
            end
            if (ack) acks++;
        end
        pwe = fl_we;
        poe = fl_oe;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // exp_res: 0 done, 1 verify_fail, 2 error
    task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input int bsy,
                          input int mode, input bit gl, input bit cor, input bit b5m,
                          input int exp_res, input int exp_rd, input bit noisy);
        int guard;
        int got;
        m_d = d; m_busy = bsy; m_mode = mode; m_glitch = gl; m_corrupt = cor; m_b5m = b5m;
        m_clr = 1'b1;
        tick();
        m_clr = 1'b0;
        req = 1'b1; req_addr = a; req_data = d;
        tick();
        chk(ack == 1'b1 && busy == 1'b1, "R2 ack", {ack, busy}, 3);
        req = 1'b0;
        if (noisy) begin
            req_addr = ~a; req_data = ~d; req = 1'b1;
            for (int k = 0; k < 6; k++) tick();
            req = 1'b0;
        end
        guard = 0;
        while (!(done || error || verify_fail) && guard < 3000) begin
            tick();
            guard++;
        end
        got = done ? 0 : verify_fail ? 1 : error ? 2 : 3;
        chk(got == exp_res, "R8 outcome", got, exp_res);
        chk($countones({done, error, verify_fail}) == 1 && !busy, "R8 single", {busy, done, error, verify_fail}, 1);
        tick();
        chk(!(done || error || verify_fail) && !busy, "R8 pulse width", {busy, done, error, verify_fail}, 0);
        chk(acks == 1, "R2 one ack", acks, 1);
        chk(wa[0] == AW'('hAAA) && wd[0] == 8'hAA, "R1 unlock1", {wa[0], wd[0]}, 20'hAAAAA);
        chk(wa[1] == AW'('h555) && wd[1] == 8'h55, "R1 unlock2", {wa[1], wd[1]}, 20'h55555);
        chk(wa[2] == AW'('hAAA) && wd[2] == 8'hA0, "R1 command", {wa[2], wd[2]}, 20'hAAAA0);
        chk(wa[3] == a && wd[3] == d, "R1 data write", {wa[3], wd[3]}, {a, d});
        chk(wlen_bad == 0, "R1 strobe length", wlen_bad, 0);
        chk(rcnt == exp_rd, "R3 R4 read count", rcnt, exp_rd);
        if (exp_res == 2) begin
            chk(wcnt == 5, "R6 R7 writes", wcnt, 5);
            chk(wa[4] == '0 && wd[4] == 8'hF0, "R6 R7 reset write", {wa[4], wd[4]}, 20'h000F0);
        end else begin
            chk(wcnt == 4, "R5 no reset write", wcnt, 4);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) tick();
        rst = 1'b0;
        tick();
        // R9 reset state
        chk({ack, busy, done, error, verify_fail, fl_we, fl_oe} == 7'b0, "R9 reset outputs",
            {ack, busy, done, error, verify_fail, fl_we, fl_oe}, 0);
        // R3 R4 sweep all data values, varying busy length and settle glitch
        for (int v = 0; v < 256; v++)
            run_op({v[3:0], v[7:0]}, v[7:0], v % 4, 0, v[2], 0, 0, 0, (v % 4) + 2, 0);
        // R5 confirming read mismatch
        run_op(12'h123, 8'h5A, 1, 0, 0, 1, 0, 1, 3, 0);
        run_op(12'h321, 8'hC3, 0, 0, 1, 1, 0, 1, 2, 0);
        // R6 device failure at several poll indices
        for (int k = 0; k < MAXP; k++)
            run_op(12'h0F0, 8'h80 | k[7:0], k, 1, 0, 0, 0, 2, k + 1, 0);
        // R6 bit 5 ignored when bit 7 matches
        run_op(12'h777, 8'h03, 2, 0, 0, 0, 1, 0, 4, 0);
        // R7 poll limit
        run_op(12'hABC, 8'h7E, 0, 2, 0, 0, 0, 2, MAXP, 0);
        run_op(12'hABD, 8'hFF, 0, 2, 0, 0, 0, 2, MAXP, 0);
        // R2 requests while busy are ignored
        run_op(12'h246, 8'h39, 2, 0, 0, 0, 0, 0, 4, 1);
        run_op(12'h468, 8'hA6, 0, 2, 0, 0, 0, 2, MAXP, 1);
        tick();
        chk(!busy && !fl_we && !fl_oe, "R2 idle after", {busy, fl_we, fl_oe}, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule